// File: doc/BRIEF.md
# PCI Configuration Address Port

This block sits on the host I/O path of a PCI host bridge that uses the DWORD-based configuration mechanism. It holds the 32-bit configuration-address register and decides, access by access, whether to claim a host I/O cycle or pass it on. A cycle is claimed only when it targets the register's DWORD and enables all four byte lanes. A claimed write stores the data. A claimed read returns the stored value. Any other cycle goes out unchanged on a downstream PCI I/O request port. This includes byte or word cycles that overlap the register's bytes.

Because of this split, software can probe the register with a DWORD write followed by a byte write to one of its bytes. A DWORD read-back then still returns the first value. Byte-wide or word-wide devices that share those I/O addresses keep working, because their cycles are never swallowed.

The host holds a strobe until it sees ready. A claimed cycle is acknowledged in the next clock cycle. A forwarded cycle is acknowledged by the downstream ready.

Top module: `pci_cfg_addr_port`

## Requirements
- R1: After reset the register holds 0x00000000, so a full DWORD read of byte address 0xCF8 returns 0x00000000.
- R2: A write with byte enables 4'b1111 to byte address 0xCF8 loads all 32 bits of write data into the register.
- R3: A read with byte enables 4'b1111 from byte address 0xCF8 returns the full register value on `h_rdata`. Address bits [15:2] select the DWORD and bit i of the byte enable selects data bits [8i+7:8i].
- R4: A claimed cycle raises `h_ready` in the clock cycle after the request is first presented. No downstream strobe is raised while it is in progress.
- R5: Any cycle to byte addresses 0xCF8–0xCFB whose byte enable is not 4'b1111 leaves the register unchanged. For example, a DWORD write of 0x80000000, then a byte write of 0x01 to 0xCFB (byte enable 4'b1000), then a DWORD read returns 0x80000000.
- R6: Such partial cycles appear on the downstream port with address, byte enables, write data and strobe unchanged, in the same cycle.
- R7: Cycles to any byte address outside 0xCF8–0xCFB are forwarded unchanged, whatever their byte enables.
- R8: For a forwarded cycle, `h_rdata` equals `dn_rdata` and `h_ready` equals `dn_ready`.
- R9: If `h_rd` and `h_wr` are both high, the cycle is treated as a write. Only `dn_wr` is raised when it is forwarded, and the register loads when it is claimed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | 16 | Host I/O byte address |
| h_be | input | 4 | Host byte-lane enables |
| h_rd | input | 1 | Host read strobe, held until ready |
| h_wr | input | 1 | Host write strobe, held until ready |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Read data returned to host |
| h_ready | output | 1 | Host cycle completion |
| dn_addr | output | 16 | Downstream I/O byte address |
| dn_be | output | 4 | Downstream byte-lane enables |
| dn_rd | output | 1 | Downstream read strobe |
| dn_wr | output | 1 | Downstream write strobe |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data |
| dn_ready | input | 1 | Downstream completion |

## Verification
The assertions check the following on every cycle:
- a claimed request is acknowledged one cycle later;
- a claimed write loads exactly the presented data;
- the register holds its value whenever no claimed write occurs;
- the downstream strobes are never both high, and are never raised for a claimed cycle.

Only the bench scenarios can show the following:
- that the claim decision is right across every byte-enable pattern, at every byte of the register's DWORD and at neighbouring DWORDs;
- that the probe sequence of a DWORD write, then a byte write, then a read returns the first value;
- that forwarded read data and ready follow the downstream port.

// File: rtl/pci_cfg_addr_pkg.sv
package pci_cfg_addr_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam logic [ADDR_W-1:0] CFG_ADDR_LOC = 16'h0CF8;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } host_op_e;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import pci_cfg_addr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NL = LANES,
  parameter logic [AW-1:0] REG_LOC = CFG_ADDR_LOC
) (
  input  logic [AW-1:0] addr,
  input  logic [NL-1:0] be,
  input  logic          rd,
  input  logic          wr,
  output host_op_e      op,
  output logic          claim
);
  localparam int unsigned SEL_LSB = $clog2(NL);

  logic dword_hit;
  logic full_lanes;

  always_comb begin
    dword_hit  = (addr[AW-1:SEL_LSB] == REG_LOC[AW-1:SEL_LSB]);
    full_lanes = &be;
    // write wins when both strobes are raised
    if (wr)      op = OP_WRITE;
    else if (rd) op = OP_READ;
    else         op = OP_NONE;
    claim = dword_hit && full_lanes && (op != OP_NONE);
  end
endmodule

// File: rtl/cfg_addr_store.sv
module cfg_addr_store
  import pci_cfg_addr_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NL = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          claim,
  input  host_op_e      op,
  input  logic [NL-1:0] be,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] reg_q,
  output logic [DW-1:0] rdata_q,
  output logic          ack_q
);
  logic take;
  logic ld;

  always_comb begin
    take = claim && !ack_q;
    ld   = take && (op == OP_WRITE);
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        reg_q[g*8 +: 8] <= '0;
      else if (ld && be[g])
        reg_q[g*8 +: 8] <= wdata[g*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= take;
      rdata_q <= (take && op == OP_READ) ? (reg_q & lane_mask(be)) : '0;
    end
  end

  // R4
  ack_next_chk: assert property (@(posedge clk) disable iff (rst)
    (claim && !ack_q) |=> ack_q);
  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (claim && !ack_q && op == OP_WRITE && (&be)) |=> (reg_q == $past(wdata)));
  // R5
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    !(claim && !ack_q && op == OP_WRITE) |=> $stable(reg_q));
endmodule

// File: rtl/cfg_fwd_mux.sv
module cfg_fwd_mux
  import pci_cfg_addr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NL = DW / 8
) (
  input  logic          claim,
  input  logic          ack_q,
  input  host_op_e      op,
  input  logic [AW-1:0] h_addr,
  input  logic [NL-1:0] h_be,
  input  logic [DW-1:0] h_wdata,
  input  logic [DW-1:0] rdata_q,
  output logic [DW-1:0] h_rdata,
  output logic          h_ready,
  output logic [AW-1:0] dn_addr,
  output logic [NL-1:0] dn_be,
  output logic          dn_rd,
  output logic          dn_wr,
  output logic [DW-1:0] dn_wdata,
  input  logic [DW-1:0] dn_rdata,
  input  logic          dn_ready
);
  logic pass;

  always_comb begin
    pass     = !claim && !ack_q;
    dn_addr  = h_addr;
    dn_be    = h_be;
    dn_wdata = h_wdata;
    dn_rd    = pass && (op == OP_READ);
    dn_wr    = pass && (op == OP_WRITE);
    if (ack_q) begin
      h_ready = 1'b1;
      h_rdata = rdata_q;
    end else if (dn_rd || dn_wr) begin
      h_ready = dn_ready;
      h_rdata = dn_rdata;
    end else begin
      h_ready = 1'b0;
      h_rdata = '0;
    end
  end
endmodule

// File: rtl/pci_cfg_addr_port.sv
module pci_cfg_addr_port
  import pci_cfg_addr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NL = DW / 8,
  parameter logic [AW-1:0] REG_LOC = CFG_ADDR_LOC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] h_addr,
  input  logic [NL-1:0] h_be,
  input  logic          h_rd,
  input  logic          h_wr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          h_ready,
  output logic [AW-1:0] dn_addr,
  output logic [NL-1:0] dn_be,
  output logic          dn_rd,
  output logic          dn_wr,
  output logic [DW-1:0] dn_wdata,
  input  logic [DW-1:0] dn_rdata,
  input  logic          dn_ready
);
  host_op_e      op;
  logic          claim;
  logic          ack_q;
  logic [DW-1:0] reg_q;
  logic [DW-1:0] rdata_q;

  cfg_addr_decode #(.AW(AW), .NL(NL), .REG_LOC(REG_LOC)) dec_i (
    .addr(h_addr), .be(h_be), .rd(h_rd), .wr(h_wr), .op(op), .claim(claim)
  );

  cfg_addr_store #(.DW(DW), .NL(NL)) store_i (
    .clk(clk), .rst(rst), .claim(claim), .op(op), .be(h_be),
    .wdata(h_wdata), .reg_q(reg_q), .rdata_q(rdata_q), .ack_q(ack_q)
  );

  cfg_fwd_mux #(.AW(AW), .DW(DW), .NL(NL)) fwd_i (
    .claim(claim), .ack_q(ack_q), .op(op), .h_addr(h_addr), .h_be(h_be),
    .h_wdata(h_wdata), .rdata_q(rdata_q), .h_rdata(h_rdata), .h_ready(h_ready),
    .dn_addr(dn_addr), .dn_be(dn_be), .dn_rd(dn_rd), .dn_wr(dn_wr),
    .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_ready(dn_ready)
  );

  // R9
  one_dn_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dn_rd, dn_wr}));
  // R4
  claim_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (claim || ack_q) |-> !(dn_rd || dn_wr));
endmodule

// File: tb/pci_cfg_addr_port_tb.sv
module pci_cfg_addr_port_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] h_addr = '0;
  logic [3:0]  h_be = '0;
  logic        h_rd = 1'b0, h_wr = 1'b0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        h_ready;
  logic [15:0] dn_addr;
  logic [3:0]  dn_be;
  logic        dn_rd, dn_wr;
  logic [31:0] dn_wdata;
  logic [31:0] dn_rdata;
  logic        dn_ready = 1'b1;

  int checks = 0;
  int errors = 0;

  assign dn_rdata = {dn_addr, ~dn_addr};

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_cfg_addr_port dut_i (
    .clk(clk), .rst(rst), .h_addr(h_addr), .h_be(h_be), .h_rd(h_rd), .h_wr(h_wr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready), .dn_addr(dn_addr),
    .dn_be(dn_be), .dn_rd(dn_rd), .dn_wr(dn_wr), .dn_wdata(dn_wdata),
    .dn_rdata(dn_rdata), .dn_ready(dn_ready)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // claimed full-DWORD cycle at 0xCF8; returns read data
  task automatic claimed(input bit wr, input bit rd, input logic [31:0] wd,
                         output logic [31:0] rdv);
    @(negedge clk);
    h_addr = 16'h0CF8; h_be = 4'hF; h_wr = wr; h_rd = rd; h_wdata = wd;
    #1;
    chk("R4 no downstream strobe", {dn_rd, dn_wr}, 2'b00);
    chk("R4 not ready in request cycle", h_ready, 1'b0);
    @(negedge clk);
    chk("R4 ready next cycle", h_ready, 1'b1);
    chk("R4 quiet while acked", {dn_rd, dn_wr}, 2'b00);
    rdv = h_rdata;
    h_wr = 0; h_rd = 0; h_be = 0;
  endtask

  // forwarded cycle: checks pass-through in the request cycle
  task automatic forwarded(input string req, input logic [15:0] a, input logic [3:0] be,
                           input bit wr, input bit rd, input logic [31:0] wd);
    @(negedge clk);
    h_addr = a; h_be = be; h_wr = wr; h_rd = rd; h_wdata = wd;
    #1;
    chk({req, " addr"}, dn_addr, a);
    chk({req, " be"}, dn_be, be);
    chk({req, " wdata"}, dn_wdata, wd);
    chk({req, " strobes (R9)"}, {dn_rd, dn_wr}, {rd & ~wr, wr});
    chk({req, " ready (R8)"}, h_ready, dn_ready);
    if (rd && !wr) chk({req, " rdata (R8)"}, h_rdata, {a, ~a});
    @(negedge clk);
    h_wr = 0; h_rd = 0; h_be = 0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1
    claimed(0, 1, '0, rv);
    chk("R1 reset value", rv, 32'h0);
    // R2 R3
    claimed(1, 0, 32'hA5C3_1E77, rv);
    claimed(0, 1, '0, rv);
    chk("R2/R3 readback", rv, 32'hA5C3_1E77);
    // R5 probe sequence
    claimed(1, 0, 32'h8000_0000, rv);
    forwarded("R6 byte to CFB", 16'h0CFB, 4'b1000, 1, 0, 32'h0100_0000);
    claimed(0, 1, '0, rv);
    chk("R5 probe readback", rv, 32'h8000_0000);
    // R5 R6 sweep over all partial enables at every byte of the DWORD
    for (int b = 0; b < 4; b++) begin
      for (int e = 0; e < 15; e++) begin
        forwarded("R6 partial", 16'h0CF8 + 16'(b), 4'(e), 1, 0, 32'hFFFF_FFFF);
        forwarded("R6 partial rd", 16'h0CF8 + 16'(b), 4'(e), 0, 1, '0);
      end
    end
    claimed(0, 1, '0, rv);
    chk("R5 unchanged after sweep", rv, 32'h8000_0000);
    // R7 neighbours, any size
    for (int e = 0; e < 16; e++) begin
      forwarded("R7 below", 16'h0CF4, 4'(e), 1, 0, 32'h1234_5678);
      forwarded("R7 above", 16'h0CFC, 4'(e), 0, 1, '0);
      forwarded("R7 far", 16'h8CF8, 4'(e), 1, 0, 32'h0BAD_F00D);
    end
    claimed(0, 1, '0, rv);
    chk("R7 register untouched", rv, 32'h8000_0000);
    // R8 ready follows downstream
    dn_ready = 0;
    forwarded("R8 stalled", 16'h0CFC, 4'hF, 0, 1, '0);
    dn_ready = 1;
    // R9 both strobes
    forwarded("R9 both fwd", 16'h0CF9, 4'b0011, 1, 1, 32'h5555_AAAA);
    claimed(1, 1, 32'h1357_9BDF, rv);
    claimed(0, 1, '0, rv);
    chk("R9 write priority on claim", rv, 32'h1357_9BDF);
    // R1 reset again
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    claimed(0, 1, '0, rv);
    chk("R1 reset clears", rv, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule